// File: doc/BRIEF.md
# BCD to seven-segment decoder with blanking

This block turns one binary-coded decimal digit into the seven segment lines of a display whose segments light when driven low. The segments are named a through g. It has no clock and no state. Codes 10 through 15 are not decimal digits, and each of them shows a single dash.

Three control inputs sit on top of the decode, all active low. The lamp-test input lights every segment so a technician can look for dead segments. The blanking input turns the whole digit dark. The ripple-blank input darkens the digit only when it holds a zero.

The ripple-blank output goes low whenever the digit is dark because of blanking. Multi-digit displays use it to suppress leading zeros. Tie the most significant decoder's ripple-blank input low, and feed each decoder's ripple-blank output into the ripple-blank input of the next less significant decoder. Tie the units digit's ripple-blank input high so that a value of zero still shows one "0". The blanking input and the ripple-blank output belong to one function: forcing the blanking input low also drives the ripple-blank output low, so the blank condition carries on down the chain.

Top module: `bcd_seg_decoder`

## Requirements
- R1: With lamp_test_n, blank_in_n and rbi_n high, codes 0 to 9 drive seg_n = ~P, where P is the lit set with bit 0 = a through bit 6 = g. The lit sets are 0:0x3F, 1:0x06, 2:0x5B, 3:0x4F, 4:0x66, 5:0x6D, 6:0x7D, 7:0x07, 8:0x7F, 9:0x6F. rbo_n is high.
- R2: With lamp test and blanking inactive, codes 10 to 15 light only segment g (seg_n = 7'b0111111) whatever rbi_n is, and rbo_n is high.
- R3: When lamp_test_n is low, seg_n is 7'b0000000 and rbo_n is high, whatever digit, rbi_n and blank_in_n are.
- R4: When blank_in_n is low and lamp_test_n is high, seg_n is 7'b1111111 and rbo_n is low, whatever digit and rbi_n are.
- R5: When rbi_n is low, the digit is 0, and lamp_test_n and blank_in_n are high, seg_n is 7'b1111111 and rbo_n is low.
- R6: When rbi_n is low and the digit is not 0, with lamp test and blanking inactive, the normal pattern of R1 or R2 is shown and rbo_n is high.
- R7: rbo_n is high whenever any segment is lit, and low only when all segments are dark.
- R8: In a chain built as described above, leading zeros of a multi-digit value are dark, the first non-zero digit and every digit below it are shown, and a value of zero shows only the units "0".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digit | input | 4 | BCD code to display |
| lamp_test_n | input | 1 | Active-low lamp test, lights all segments |
| rbi_n | input | 1 | Active-low ripple-blank input, blanks a zero |
| blank_in_n | input | 1 | Active-low blanking input, blanks the digit |
| seg_n | output | 7 | Active-low segment lines, bit 0 = a … bit 6 = g |
| rbo_n | output | 1 | Active-low ripple-blank output, low when the digit is blanked |

## Verification
The block has no parameters. The bench drives one stand-alone instance through every combination of the seven input bits, which exercises every priority case between lamp test, blanking and ripple blanking for every code. It also builds a chain of four decoders, wired to suppress leading zeros. Random and directed four-digit values applied to that chain show how the blank condition travels between decoders, including all-zero values and values with a zero inside them.

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder (
  input  logic [3:0] digit,
  input  logic       lamp_test_n,
  input  logic       rbi_n,
  input  logic       blank_in_n,
  output logic [6:0] seg_n,
  output logic       rbo_n
);

  logic [6:0] glyph;
  logic       zero_blank;
  logic       dark;

  always_comb begin
    unique case (digit)
      4'd0:    glyph = 7'h3F;
      4'd1:    glyph = 7'h06;
      4'd2:    glyph = 7'h5B;
      4'd3:    glyph = 7'h4F;
      4'd4:    glyph = 7'h66;
      4'd5:    glyph = 7'h6D;
      4'd6:    glyph = 7'h7D;
      4'd7:    glyph = 7'h07;
      4'd8:    glyph = 7'h7F;
      4'd9:    glyph = 7'h6F;
      default: glyph = 7'h40;
    endcase
  end

  assign zero_blank = !rbi_n && (digit == 4'd0);
  assign dark       = lamp_test_n && (!blank_in_n || zero_blank);

  assign seg_n = !lamp_test_n ? 7'b0000000 : (dark ? 7'b1111111 : ~glyph);
  assign rbo_n = !dark;

  always_comb begin
    if (!lamp_test_n)
      assert_lamp_all_on_R3: assert (seg_n == 7'b0000000 && rbo_n);
    if (lamp_test_n && !blank_in_n)
      assert_blank_dark_R4: assert (seg_n == 7'b1111111 && !rbo_n);
    if (lamp_test_n && blank_in_n && !rbi_n && digit == 4'd0)
      assert_zero_ripple_R5: assert (seg_n == 7'b1111111 && !rbo_n);
    if (lamp_test_n && blank_in_n && digit != 4'd0)
      assert_nonzero_shown_R6: assert (rbo_n && seg_n != 7'b1111111);
    if (seg_n != 7'b1111111)
      assert_lit_rbo_high_R7: assert (rbo_n);
  end

endmodule

// File: tb/test_bcd_seg_decoder.sv
module test_bcd_seg_decoder;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] digit;
  logic       lt_n, rbi_n, bi_n;
  logic [6:0] seg_n;
  logic       rbo_n;

  bcd_seg_decoder i_bcd_seg_decoder (
    .digit(digit), .lamp_test_n(lt_n), .rbi_n(rbi_n), .blank_in_n(bi_n),
    .seg_n(seg_n), .rbo_n(rbo_n)
  );

  logic [3:0] cd [4];
  logic [6:0] cseg [4];
  logic       crbo [4];
  logic       crbi [4];

  assign crbi[3] = 1'b0;
  assign crbi[2] = crbo[3];
  assign crbi[1] = crbo[2];
  assign crbi[0] = 1'b1;

  for (genvar k = 0; k < 4; k++) begin : g_chain
    bcd_seg_decoder i_digit (
      .digit(cd[k]), .lamp_test_n(1'b1), .rbi_n(crbi[k]), .blank_in_n(1'b1),
      .seg_n(cseg[k]), .rbo_n(crbo[k])
    );
  end

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  function automatic logic [6:0] lit_set(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
      4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
      4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
      4'd9: return 7'h6F;  default: return 7'h40;
    endcase
  endfunction

  function automatic logic [7:0] model(input logic [3:0] d, input logic lt,
                                       input logic rbi, input logic bi);
    if (!lt) return {1'b1, 7'b0000000};
    if (!bi) return {1'b0, 7'b1111111};
    if (!rbi && d == 4'd0) return {1'b0, 7'b1111111};
    return {1'b1, ~lit_set(d)};
  endfunction

  function automatic string tag_of(input logic [3:0] d, input logic lt,
                                   input logic rbi, input logic bi);
    if (!lt) return "R3";
    if (!bi) return "R4";
    if (!rbi && d == 4'd0) return "R5";
    if (!rbi) return "R6";
    if (d > 4'd9) return "R2";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual rbo_n,seg_n=%b expected %b", tag, act, exp);
    end
    if (act[6:0] != 7'b1111111 && !act[7]) begin
      nerr++;
      $display("FAIL R7: segment lit with rbo_n low, actual %b expected rbo_n=1", act);
    end
  endtask

  task automatic apply(input logic [3:0] d, input logic lt, input logic rbi, input logic bi);
    @(posedge clk);
    digit = d; lt_n = lt; rbi_n = rbi; bi_n = bi;
    @(negedge clk);
    check(tag_of(d, lt, rbi, bi), {rbo_n, seg_n}, model(d, lt, rbi, bi));
  endtask

  task automatic apply_chain(input int value);
    logic [3:0] dd [4];
    logic       lead;
    int v;
    v = value;
    for (int k = 0; k < 4; k++) begin
      dd[k] = 4'(v % 10);
      v = v / 10;
    end
    @(posedge clk);
    for (int k = 0; k < 4; k++) cd[k] = dd[k];
    @(negedge clk);
    lead = 1'b1;
    for (int k = 3; k >= 0; k--) begin
      logic [7:0] exp;
      if (k == 0) lead = 1'b0;
      if (dd[k] != 4'd0) lead = 1'b0;
      exp = lead ? {1'b0, 7'b1111111} : {1'b1, ~lit_set(dd[k])};
      if ({crbo[k], cseg[k]} !== exp) begin
        nerr++;
        $display("FAIL R8: value %0d digit %0d actual %b expected %b",
                 value, k, {crbo[k], cseg[k]}, exp);
      end
      nvec++;
    end
  endtask

  initial begin
    digit = 4'd0; lt_n = 1'b1; rbi_n = 1'b1; bi_n = 1'b1;
    for (int k = 0; k < 4; k++) cd[k] = 4'd0;
    void'($urandom(32'd2024));
    @(negedge clk);
    check("R1", {rbo_n, seg_n}, {1'b1, ~7'h3F});
    apply(4'd8, 1'b0, 1'b0, 1'b0);
    apply(4'd0, 1'b0, 1'b0, 1'b1);
    apply(4'd7, 1'b1, 1'b1, 1'b0);
    apply(4'd0, 1'b1, 1'b0, 1'b1);
    apply(4'd0, 1'b1, 1'b1, 1'b1);
    apply(4'd12, 1'b1, 1'b0, 1'b1);
    apply(4'd5, 1'b1, 1'b0, 1'b1);
    for (int c = 0; c < 128; c++)
      apply(c[3:0], c[4], c[5], c[6]);
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r[3:0], r[6:4] != 3'd0, r[7], r[10:8] != 3'd0);
    end
    apply_chain(0);
    apply_chain(42);
    apply_chain(7);
    apply_chain(1000);
    apply_chain(9999);
    apply_chain(305);
    for (int n = 0; n < 200; n++)
      apply_chain(int'($urandom % 10000));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule